// File: doc/BRIEF.md
# Page Access Rights Evaluator

This unit decides the read, write and execute rights for one translation in a 64-bit hashed page table MMU. Two separate sources of permission feed it. The first is a protection table. The segment key and the page's 3-bit protection code select an entry in that table, and the page and segment no-execute and guarded bits then limit execute. The second is a per-class authority mask. The page's class key picks a 2-bit field from a 64-bit mask register to grant read and write.

The unit evaluates both sources in parallel and ANDs them to form the effective rights. It also keeps both partial results visible so that fault logic can tell which source denied an access. A valid strobe captures one evaluation. All three results appear registered one cycle later and hold until the next strobe.

Every rights vector is 3 bits wide: bit 2 is execute, bit 1 is write and bit 0 is read.

Top module: `access_rights_eval`

## Requirements
- R1: The access key is `seg_key_user_i` when `prob_state_i` is 1, and `seg_key_super_i` when `prob_state_i` is 0.
- R2: The protection code is {`pte_pp_ext_i`, `pte_pp_i[1:0]`}, with `pte_pp_ext_i` as the most significant bit.
- R3: With key 0, codes 0, 1 and 2 give read+write (pp read/write bits 2'b11), codes 3 and 6 give read only (2'b01), and codes 4, 5 and 7 give nothing.
- R4: With key 1, code 2 gives read+write, codes 1 and 3 give read only, and codes 0, 4, 5, 6 and 7 give nothing.
- R5: The execute bit of `pp_rights_o` is 1 only when `pte_noexec_i`, `pte_guard_i` and `seg_noexec_i` are all 0.
- R6: With class protection enabled, the field is `auth_mask_i[2*(31-k)+1 : 2*(31-k)]` for class key k. The upper bit of the field grants write, the lower bit grants read, and execute is always granted.
- R7: With `class_en_i` at 0, `class_rights_o` is 3'b111 whatever the mask and class key.
- R8: `rights_o` equals `pp_rights_o & class_rights_o`.
- R9: Results and `valid_o` update one cycle after `valid_i`. While `valid_i` is 0, `valid_o` is 0 one cycle later and all rights outputs hold their values.
- R10: After reset, `valid_o` and all rights outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Evaluate strobe |
| prob_state_i | input | 1 | Problem (user) state |
| seg_key_super_i | input | 1 | Segment supervisor key bit |
| seg_key_user_i | input | 1 | Segment problem-state key bit |
| seg_noexec_i | input | 1 | Segment no-execute |
| pte_pp_ext_i | input | 1 | Page extra protection bit (code MSB) |
| pte_pp_i | input | 2 | Page ordinary protection bits |
| pte_noexec_i | input | 1 | Page no-execute |
| pte_guard_i | input | 1 | Page guarded |
| pte_class_i | input | 5 | Page class key |
| auth_mask_i | input | 64 | Class authority mask |
| class_en_i | input | 1 | Class-key protection enable |
| valid_o | output | 1 | Results valid |
| pp_rights_o | output | 3 | Protection-table rights {x,w,r} |
| class_rights_o | output | 3 | Class-key rights {x,w,r} |
| rights_o | output | 3 | Effective rights {x,w,r} |

## Verification
The bench sweeps all eight protection codes under both key values. This tells the two tables apart and catches entries that are swapped between them. Two cases pin down key selection and bit order. Opposite supervisor and problem-state key bits are driven in both states. Code 6 is used because reversing the bit order would turn it into code 5.

Mask tests put distinct patterns in the fields of the first, last and a middle class key, so a mirrored field index or swapped read and write bits produce wrong rights. Other tests set each no-execute source alone, disable class protection under a zero mask, mix the two sources to prove the intersection, and change inputs without a strobe to show that the outputs hold.

// File: rtl/access_rights_pkg.sv
package access_rights_pkg;
  typedef logic [2:0] rights_t;  // {exec, write, read}
  localparam int unsigned RD_BIT = 0;
  localparam int unsigned WR_BIT = 1;
  localparam int unsigned EX_BIT = 2;
  localparam rights_t RIGHTS_NONE = 3'b000;
  localparam rights_t RIGHTS_ALL  = 3'b111;
endpackage

// File: rtl/pp_rights_table.sv
module pp_rights_table
  import access_rights_pkg::*;
#(
  parameter int unsigned CODE_W = 3
) (
  input  logic              key_i,
  input  logic [CODE_W-1:0] code_i,
  input  logic              pte_noexec_i,
  input  logic              pte_guard_i,
  input  logic              seg_noexec_i,
  output rights_t           rights_o
);
  logic [1:0] rw;  // {write, read}

  always_comb begin
    rw = 2'b00;
    if (!key_i) begin
      unique case (code_i)
        3'd0, 3'd1, 3'd2: rw = 2'b11;
        3'd3, 3'd6:       rw = 2'b01;
        default:          rw = 2'b00;
      endcase
    end else begin
      unique case (code_i)
        3'd2:       rw = 2'b11;
        3'd1, 3'd3: rw = 2'b01;
        default:    rw = 2'b00;
      endcase
    end
  end

  assign rights_o = {~(pte_noexec_i | pte_guard_i | seg_noexec_i), rw};
endmodule

// File: rtl/class_key_rights.sv
module class_key_rights
  import access_rights_pkg::*;
#(
  parameter int unsigned KEY_W = 5
) (
  input  logic                    en_i,
  input  logic [KEY_W-1:0]        key_i,
  input  logic [2*(1<<KEY_W)-1:0] mask_i,
  output rights_t                 rights_o
);
  localparam int unsigned NUM_CLASSES = 1 << KEY_W;

  logic [1:0] field [NUM_CLASSES];
  logic [1:0] sel;

  // Class 0 sits in the top pair of the mask
  for (genvar g = 0; g < NUM_CLASSES; g++) begin : g_field
    assign field[g] = mask_i[2*(NUM_CLASSES-1-g) +: 2];
  end

  assign sel      = field[key_i];
  assign rights_o = en_i ? {1'b1, sel[1], sel[0]} : RIGHTS_ALL;
endmodule

// File: rtl/access_rights_eval.sv
module access_rights_eval
  import access_rights_pkg::*;
#(
  parameter int unsigned CLASS_KEY_W = 5,
  localparam int unsigned MASK_W     = 2 * (1 << CLASS_KEY_W)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   valid_i,
  input  logic                   prob_state_i,
  input  logic                   seg_key_super_i,
  input  logic                   seg_key_user_i,
  input  logic                   seg_noexec_i,
  input  logic                   pte_pp_ext_i,
  input  logic [1:0]             pte_pp_i,
  input  logic                   pte_noexec_i,
  input  logic                   pte_guard_i,
  input  logic [CLASS_KEY_W-1:0] pte_class_i,
  input  logic [MASK_W-1:0]      auth_mask_i,
  input  logic                   class_en_i,
  output logic                   valid_o,
  output logic [2:0]             pp_rights_o,
  output logic [2:0]             class_rights_o,
  output logic [2:0]             rights_o
);
  logic    key;
  rights_t pp_d, cls_d;

  assign key = prob_state_i ? seg_key_user_i : seg_key_super_i;

  pp_rights_table #(.CODE_W(3)) u_pp (
    .key_i        (key),
    .code_i       ({pte_pp_ext_i, pte_pp_i}),
    .pte_noexec_i (pte_noexec_i),
    .pte_guard_i  (pte_guard_i),
    .seg_noexec_i (seg_noexec_i),
    .rights_o     (pp_d)
  );

  class_key_rights #(.KEY_W(CLASS_KEY_W)) u_cls (
    .en_i     (class_en_i),
    .key_i    (pte_class_i),
    .mask_i   (auth_mask_i),
    .rights_o (cls_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o        <= 1'b0;
      pp_rights_o    <= RIGHTS_NONE;
      class_rights_o <= RIGHTS_NONE;
      rights_o       <= RIGHTS_NONE;
    end else begin
      valid_o <= valid_i;
      if (valid_i) begin
        pp_rights_o    <= pp_d;
        class_rights_o <= cls_d;
        rights_o       <= pp_d & cls_d;
      end
    end
  end
endmodule

// File: rtl/access_rights_eval_chk.sv
module access_rights_eval_chk #(
  parameter int unsigned CLASS_KEY_W = 5
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       valid_i,
  input logic       seg_noexec_i,
  input logic       pte_noexec_i,
  input logic       pte_guard_i,
  input logic       class_en_i,
  input logic       valid_o,
  input logic [2:0] pp_rights_o,
  input logic [2:0] class_rights_o,
  input logic [2:0] rights_o
);
  AST_EFFECTIVE_AND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rights_o == (pp_rights_o & class_rights_o)); // R8
  AST_VALID_DELAY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && $stable(rights_o) && $stable(pp_rights_o))); // R9
  AST_CLASS_EXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> class_rights_o[2]); // R6
  AST_CLASS_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && !class_en_i) |=> class_rights_o == 3'b111); // R7
  AST_NOEXEC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && (seg_noexec_i || pte_noexec_i || pte_guard_i)) |=> !pp_rights_o[2]); // R5
  AST_WRITE_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pp_rights_o[1] |-> pp_rights_o[0]); // R3 R4
endmodule

bind access_rights_eval access_rights_eval_chk #(.CLASS_KEY_W(CLASS_KEY_W)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .valid_i        (valid_i),
  .seg_noexec_i   (seg_noexec_i),
  .pte_noexec_i   (pte_noexec_i),
  .pte_guard_i    (pte_guard_i),
  .class_en_i     (class_en_i),
  .valid_o        (valid_o),
  .pp_rights_o    (pp_rights_o),
  .class_rights_o (class_rights_o),
  .rights_o       (rights_o)
);

// File: tb/access_rights_eval_test.sv
`timescale 1ns/1ps
module access_rights_eval_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic        prob_state_i = 1'b0;
  logic        seg_key_super_i = 1'b0;
  logic        seg_key_user_i = 1'b0;
  logic        seg_noexec_i = 1'b0;
  logic        pte_pp_ext_i = 1'b0;
  logic [1:0]  pte_pp_i = 2'b00;
  logic        pte_noexec_i = 1'b0;
  logic        pte_guard_i = 1'b0;
  logic [4:0]  pte_class_i = 5'd0;
  logic [63:0] auth_mask_i = 64'd0;
  logic        class_en_i = 1'b0;
  logic        valid_o;
  logic [2:0]  pp_rights_o, class_rights_o, rights_o;

  int n_run = 0;
  int n_fail = 0;

  always #4 clk_i = ~clk_i;

  access_rights_eval uut (.*);

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Expected {w,r} from protection tables
  function automatic logic [1:0] exp_rw(input logic key, input logic [2:0] code);
    if (!key) return (code <= 3'd2) ? 2'b11 : ((code == 3'd3 || code == 3'd6) ? 2'b01 : 2'b00);
    return (code == 3'd2) ? 2'b11 : ((code == 3'd1 || code == 3'd3) ? 2'b01 : 2'b00);
  endfunction

  // One strobed evaluation; outputs sampled at the following negedge
  task automatic eval(input logic ps, input logic ks, input logic ku, input logic [2:0] code,
                      input logic nx, input logic gd, input logic snx,
                      input logic [4:0] ck, input logic [63:0] mask, input logic en);
    @(negedge clk_i);
    valid_i = 1'b1; prob_state_i = ps; seg_key_super_i = ks; seg_key_user_i = ku;
    pte_pp_ext_i = code[2]; pte_pp_i = code[1:0];
    pte_noexec_i = nx; pte_guard_i = gd; seg_noexec_i = snx;
    pte_class_i = ck; auth_mask_i = mask; class_en_i = en;
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 valid", valid_o, 0);
    chk("R10 pp", pp_rights_o, 0);
    chk("R10 class", class_rights_o, 0);
    chk("R10 rights", rights_o, 0);
  endtask

  task automatic t_tables();
    for (int k = 0; k < 2; k++) begin
      for (int c = 0; c < 8; c++) begin
        eval(1'b0, k[0], 1'b0, c[2:0], 1'b0, 1'b0, 1'b0, 5'd0, 64'd0, 1'b0);
        chk(k == 0 ? "R3 key0 table" : "R4 key1 table", pp_rights_o,
            {1'b1, exp_rw(k[0], c[2:0])});
        chk("R9 valid_o", valid_o, 1);
      end
    end
  endtask

  task automatic t_key_select();
    // supervisor key 0, problem key 1, code 0
    eval(1'b0, 1'b0, 1'b1, 3'd0, 0, 0, 0, 5'd0, 64'd0, 1'b0);
    chk("R1 supervisor key", pp_rights_o, 3'b111);
    eval(1'b1, 1'b0, 1'b1, 3'd0, 0, 0, 0, 5'd0, 64'd0, 1'b0);
    chk("R1 problem key", pp_rights_o, 3'b100);
    eval(1'b1, 1'b1, 1'b0, 3'd2, 0, 0, 0, 5'd0, 64'd0, 1'b0);
    chk("R1 problem key0", pp_rights_o, 3'b111);
  endtask

  task automatic t_code_order();
    eval(1'b0, 1'b0, 1'b0, 3'd6, 0, 0, 0, 5'd0, 64'd0, 1'b0);
    chk("R2 code 6 ordering", pp_rights_o, 3'b101);
  endtask

  task automatic t_exec();
    eval(0, 0, 0, 3'd0, 1, 0, 0, 5'd0, 64'd0, 1'b0);
    chk("R5 page noexec", pp_rights_o, 3'b011);
    eval(0, 0, 0, 3'd0, 0, 1, 0, 5'd0, 64'd0, 1'b0);
    chk("R5 guarded", pp_rights_o, 3'b011);
    eval(0, 0, 0, 3'd0, 0, 0, 1, 5'd0, 64'd0, 1'b0);
    chk("R5 segment noexec", pp_rights_o, 3'b011);
  endtask

  task automatic t_class_field();
    logic [63:0] m;
    m = 64'd0;
    m[63:62] = 2'b10;   // class 0: write only
    m[1:0]   = 2'b01;   // class 31: read only
    m[53:52] = 2'b11;   // class 5: read+write
    eval(0, 0, 0, 3'd0, 0, 0, 0, 5'd0, m, 1'b1);
    chk("R6 class 0", class_rights_o, 3'b110);
    eval(0, 0, 0, 3'd0, 0, 0, 0, 5'd31, m, 1'b1);
    chk("R6 class 31", class_rights_o, 3'b101);
    eval(0, 0, 0, 3'd0, 0, 0, 0, 5'd5, m, 1'b1);
    chk("R6 class 5", class_rights_o, 3'b111);
    eval(0, 0, 0, 3'd0, 0, 0, 0, 5'd4, m, 1'b1);
    chk("R6 class 4 empty", class_rights_o, 3'b100);
  endtask

  task automatic t_class_off();
    eval(0, 0, 0, 3'd0, 0, 0, 0, 5'd9, 64'd0, 1'b0);
    chk("R7 disabled", class_rights_o, 3'b111);
  endtask

  task automatic t_and();
    logic [63:0] m;
    m = 64'd0;
    m[59:58] = 2'b01;   // class 2: read only
    eval(0, 0, 0, 3'd1, 0, 0, 0, 5'd2, m, 1'b1);
    chk("R8 and rw&r", rights_o, 3'b101);
    chk("R8 pp part", pp_rights_o, 3'b111);
    eval(0, 1, 0, 3'd1, 0, 1, 0, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, 1'b1);
    chk("R8 and r&all", rights_o, 3'b001);
  endtask

  task automatic t_hold();
    eval(0, 0, 0, 3'd0, 0, 0, 0, 5'd0, 64'd0, 1'b0);
    @(negedge clk_i);
    prob_state_i = 1'b1; seg_key_user_i = 1'b1; pte_pp_ext_i = 1'b1; class_en_i = 1'b1;
    pte_noexec_i = 1'b1;
    @(negedge clk_i);
    chk("R9 valid low", valid_o, 0);
    chk("R9 hold rights", rights_o, 3'b111);
    chk("R9 hold pp", pp_rights_o, 3'b111);
  endtask

  initial begin
    #30;
    t_reset();
    @(negedge clk_i);
    rst_ni = 1'b1;
    t_reset();
    t_tables();
    t_key_select();
    t_code_order();
    t_exec();
    t_class_field();
    t_class_off();
    t_and();
    t_hold();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    n_run++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule